// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block controls a port of up to eight pads. Some of the pads are shared with analog inputs, with peripheral outputs such as a comparator result, and with a reference-voltage output. Software uses a small register bus to set each pin's direction, its output latch and its analog select. Software reads the pad levels back through a synchronized port read path. Side-band inputs from peripherals can take over a pin's output driver or switch it to reference output.

Each pin resolves its pad controls by a fixed priority. Reference output comes first: it turns off both the driver and the digital input. The peripheral override comes second: it drives the peripheral's value whatever the direction bit says. The direction and latch registers come last. The analog select turns off only the digital input read and leaves the output driver alone. Pad inputs pass through two flops before they reach the port read. Input gating for analog and reference modes is applied after those flops, so it acts at once.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, the direction register reads all ones (every pin an input), the latch reads 0, and the analog select reads ANA_MASK (default 8'h2F, pins 0-3 and 5). With no override active, pad_oe is 0 on every pin.
- R2: A bus write with bus_we high takes effect at the next rising edge. The register is chosen by address: 0 = direction, 1 = latch, 3 = analog select. Reads are combinational on bus_rdata. Analog select bits outside ANA_MASK always read 0.
- R3: Suppose a pin has no reference output and no peripheral override. If its direction bit is 0, pad_oe is 1 and pad_do equals its latch bit. If its direction bit is 1, pad_oe is 0 and pad_do is 0.
- R4: The analog select bit of a pin does not change that pin's pad_oe or pad_do.
- R5: Reading address 2 returns the pad_di levels seen two rising edges earlier. A pad change is therefore not visible after only one edge.
- R6: On the address-2 read, a pin reads 0 while its analog select bit is 1 or its reference output is active. This takes effect in the same cycle as the change.
- R7: With periph_oe high and no reference output on the pin, pad_oe is 1 and pad_do equals periph_do, whatever the direction and latch bits are.
- R8: ref_en acts only on pins in REF_MASK (default 8'h04, pin 2). On such a pin it forces pad_oe to 0 and pad_do to 0, over the peripheral override and the direction bit. ref_en on any other pin has no effect.
- R9: A bus write to address 2 changes none of the direction, latch or analog select registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | N_PINS | Write data |
| bus_rdata | output | N_PINS | Read data of the addressed register |
| periph_oe | input | N_PINS | Per-pin peripheral output override enable |
| periph_do | input | N_PINS | Per-pin peripheral output value |
| ref_en | input | N_PINS | Per-pin reference-output request |
| pad_di | input | N_PINS | Pad input levels |
| pad_oe | output | N_PINS | Pad output driver enable |
| pad_do | output | N_PINS | Pad output value |

## Verification
The pad controls and bus reads are combinational. After a register write they are due one rising edge later. After a change on periph_oe, periph_do or ref_en, they are due in the same cycle. A pad input level is due on the port read after exactly two rising edges, and the bench samples it after one edge as well as after two. The bench changes inputs on the falling edge and samples just after a falling edge, so every check lands a fixed number of edges after its stimulus.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR  = 2'd0,
        REG_LAT  = 2'd1,
        REG_PORT = 2'd2,
        REG_ANA  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SRC_OFF    = 2'd0,
        SRC_LATCH  = 2'd1,
        SRC_PERIPH = 2'd2
    } drive_src_e;

    typedef struct packed {
        logic ref_act;
        logic periph;
        logic ana;
        logic dir_in;
    } pin_mode_t;

    function automatic drive_src_e pick_source(pin_mode_t m);
        if (m.ref_act)     return SRC_OFF;
        else if (m.periph) return SRC_PERIPH;
        else if (!m.dir_in) return SRC_LATCH;
        else               return SRC_OFF;
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_mux_pkg::*;
#(
    parameter int          N_PINS   = 8,
    parameter logic [N_PINS-1:0] ANA_MASK = 8'h2F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_PINS-1:0] wdata,
    input  logic [N_PINS-1:0] port_val,
    output logic [N_PINS-1:0] rdata,
    output logic [N_PINS-1:0] dir_q,
    output logic [N_PINS-1:0] lat_q,
    output logic [N_PINS-1:0] ana_q
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '1;
            lat_q <= '0;
            ana_q <= ANA_MASK;
        end else if (we) begin
            case (sel)
                REG_DIR: dir_q <= wdata;
                REG_LAT: lat_q <= wdata;
                REG_ANA: ana_q <= wdata & ANA_MASK;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            REG_DIR:  rdata = dir_q;
            REG_LAT:  rdata = lat_q;
            REG_PORT: rdata = port_val;
            REG_ANA:  rdata = ana_q;
            default:  rdata = '0;
        endcase
    end

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 2'd0) |=> (dir_q == $past(wdata)));

    // R2
    lat_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 2'd1) |=> (lat_q == $past(wdata)));

    // R9
    port_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 2'd2) |=> ($stable(dir_q) && $stable(lat_q) && $stable(ana_q)));

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_mux_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dir_in,
    input  logic lat_bit,
    input  logic ana_bit,
    input  logic periph_oe,
    input  logic periph_do,
    input  logic ref_act,
    output logic pad_oe,
    output logic pad_do,
    output logic in_en
);
    pin_mode_t  mode;
    drive_src_e src;

    always_comb begin
        mode.ref_act = ref_act;
        mode.periph  = periph_oe;
        mode.ana     = ana_bit;
        mode.dir_in  = dir_in;
        src          = pick_source(mode);
        case (src)
            SRC_LATCH: begin pad_oe = 1'b1; pad_do = lat_bit;   end
            SRC_PERIPH: begin pad_oe = 1'b1; pad_do = periph_do; end
            default:   begin pad_oe = 1'b0; pad_do = 1'b0;      end
        endcase
        in_en = !(mode.ana || mode.ref_act);
    end

    // R8
    ref_blocks_driver_chk: assert property (@(posedge clk) disable iff (rst)
        ref_act |-> (!pad_oe && !pad_do));

    // R7
    periph_drives_chk: assert property (@(posedge clk) disable iff (rst)
        (periph_oe && !ref_act) |-> (pad_oe && pad_do == periph_do));

    // R3
    latch_drives_chk: assert property (@(posedge clk) disable iff (rst)
        (!periph_oe && !ref_act && !dir_in) |-> (pad_oe && pad_do == lat_bit));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pad_di,
    input  logic [N_PINS-1:0] in_en,
    output logic [N_PINS-1:0] port_val
);
    logic [N_PINS-1:0] meta_q;
    logic [N_PINS-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pad_di;
            sync_q <= meta_q;
        end
    end

    assign port_val = sync_q & in_en;

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_mux_pkg::*;
#(
    parameter int                N_PINS   = 8,
    parameter logic [N_PINS-1:0] ANA_MASK = 8'h2F,
    parameter logic [N_PINS-1:0] REF_MASK = 8'h04
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] periph_oe,
    input  logic [N_PINS-1:0] periph_do,
    input  logic [N_PINS-1:0] ref_en,
    input  logic [N_PINS-1:0] pad_di,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_do
);
    logic [N_PINS-1:0] dir_q, lat_q, ana_q;
    logic [N_PINS-1:0] in_en, port_val, ref_act;

    assign ref_act = ref_en & REF_MASK;

    gpio_regfile #(.N_PINS(N_PINS), .ANA_MASK(ANA_MASK)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .port_val(port_val), .rdata(bus_rdata),
        .dir_q(dir_q), .lat_q(lat_q), .ana_q(ana_q)
    );

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        gpio_pin_ctrl u_pin (
            .clk(clk), .rst(rst),
            .dir_in(dir_q[i]), .lat_bit(lat_q[i]), .ana_bit(ana_q[i]),
            .periph_oe(periph_oe[i]), .periph_do(periph_do[i]),
            .ref_act(ref_act[i]),
            .pad_oe(pad_oe[i]), .pad_do(pad_do[i]), .in_en(in_en[i])
        );
    end

    gpio_in_sync #(.N_PINS(N_PINS)) u_sync (
        .clk(clk), .rst(rst), .pad_di(pad_di), .in_en(in_en),
        .port_val(port_val)
    );

    // R6
    gated_read_chk: assert property (@(posedge clk) disable iff (rst)
        ((ana_q | ref_act) & port_val) == '0);

    // R8
    ref_outside_mask_chk: assert property (@(posedge clk) disable iff (rst)
        ((ref_en & ~REF_MASK & ~periph_oe & ~dir_q) & ~pad_oe) == '0);

endmodule

// File: tb/gpio_mux_port_test.sv
`timescale 1ns/1ps
module gpio_mux_port_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         bus_we;
    logic [1:0]   bus_addr;
    logic [N-1:0] bus_wdata, bus_rdata;
    logic [N-1:0] periph_oe, periph_do, ref_en, pad_di, pad_oe, pad_do;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_mux_port uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .periph_oe(periph_oe), .periph_do(periph_do), .ref_en(ref_en),
        .pad_di(pad_di), .pad_oe(pad_oe), .pad_do(pad_do)
    );

    // fields: dir, lat, ana, poe, pdo, ref, exp_oe, exp_do
    localparam logic [63:0] VEC [6] = '{
        64'h00_A5_00_00_00_00_FF_A5,   // R3 all outputs
        64'hFF_A5_00_00_00_00_00_00,   // R3 all inputs
        64'h0F_3C_2F_00_00_00_F0_30,   // R4 analog leaves driver alone
        64'hFF_00_00_21_01_00_21_01,   // R7 override beats direction
        64'h00_FF_00_04_00_04_FB_FB,   // R8 reference beats override
        64'h00_00_00_00_00_08_FF_00    // R8 ref outside mask ignored
    };

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] r;
        rst = 1'b1; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
        periph_oe = '0; periph_do = '0; ref_en = '0; pad_di = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, r); check("R1 dir", r, 8'hFF);
        rd(2'd1, r); check("R1 lat", r, 8'h00);
        rd(2'd3, r); check("R1 ana", r, 8'h2F);
        check("R1 pad_oe", pad_oe, 8'h00);

        // vector walk
        foreach (VEC[i]) begin
            logic [63:0] v;
            v = VEC[i];
            periph_oe = v[39:32]; periph_do = v[31:24]; ref_en = v[23:16];
            wr(2'd0, v[63:56]);
            wr(2'd1, v[55:48]);
            wr(2'd3, v[47:40]);
            #1;
            check($sformatf("R3/R4/R7/R8 vec%0d oe", i), pad_oe, v[15:8]);
            check($sformatf("R3/R4/R7/R8 vec%0d do", i), pad_do, v[7:0]);
        end
        periph_oe = '0; periph_do = '0; ref_en = '0;

        // R2 write path and analog mask
        wr(2'd1, 8'h5C); rd(2'd1, r); check("R2 lat readback", r, 8'h5C);
        wr(2'd3, 8'hFF); rd(2'd3, r); check("R2 ana mask", r, 8'h2F);

        // R9 write to port address is ignored
        wr(2'd0, 8'h33);
        wr(2'd2, 8'hC0);
        rd(2'd0, r); check("R9 dir", r, 8'h33);
        rd(2'd1, r); check("R9 lat", r, 8'h5C);
        rd(2'd3, r); check("R9 ana", r, 8'h2F);

        // R5 two-edge input path
        wr(2'd3, 8'h00);
        pad_di = 8'h5A;
        @(negedge clk); rd(2'd2, r); check("R5 one edge", r, 8'h00);
        @(negedge clk); rd(2'd2, r); check("R5 two edges", r, 8'h5A);

        // R6 gating by analog and reference
        pad_di = 8'hFF;
        repeat (2) @(negedge clk);
        rd(2'd2, r); check("R6 ungated", r, 8'hFF);
        ref_en = 8'h04; rd(2'd2, r); check("R6 ref gate", r, 8'hFB);
        ref_en = 8'h00;
        wr(2'd3, 8'h21); rd(2'd2, r); check("R6 analog gate", r, 8'hDE);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule